// File: doc/BRIEF.md
# Partial Bitstream Configuration Decoder

This block sits behind a configuration port. It takes a stream of 32-bit words on a valid/ready input and reads a reduced partial bitstream out of it. Nothing is interpreted until a sync word arrives. After that, type-1 style header packets select an internal register and carry a word count. A frame-address write names the target region and the replacement module. A frame-data write declares how many frame words follow. When the last of those words is accepted, the block pulses a swap strobe that carries the region and module identifiers.

While frame data is loading, the outputs of the target region are overwritten by a pseudo-random garbage pattern on their way to the static logic. This shows whether the static side isolates itself correctly. Read packets return either a fixed identification word or previously captured module state on a separate output stream. Input is stalled while that stream is emitting. A capture command snapshots the state words of the current module. A desync command or the abort input returns the block to its unsynchronised state.

The controller has four named states. ST_UNSYNC discards words until the sync word, then goes to ST_HEADER. ST_HEADER decodes a packet:
- a write with a nonzero count goes to ST_PAYLOAD;
- a read with a nonzero count goes to ST_READOUT;
- anything else stays in ST_HEADER.

ST_PAYLOAD consumes the counted words and returns to ST_HEADER after the last one. A desync command word takes it to ST_UNSYNC instead. ST_READOUT emits one word per cycle for the count and then returns to ST_HEADER. Abort sends any state to ST_UNSYNC.

Top module: `cfg_stream_decoder`

## Requirements
- R1: After reset, in_ready is 1, and out_valid, swap_strobe and inj_en are 0.
- R2: Before the sync word 0xAA995566 is accepted, every accepted word is discarded: no readout, no injection, no swap.
- R3: A header has bits [31:29]=001, opcode in [28:27] (01 read, 10 write), register address in [17:13] and word count in [10:0]. Register addresses are: frame address 1, frame data 2, readback 3, command 4, identification 12. A header with any other type field is ignored.
- R4: The frame-address word carries the region ID in bits [9:8] and the module ID in bits [3:0]. These appear on swap_region and swap_module while swap_strobe is high.
- R5: swap_strobe is a single-cycle pulse. It is high in the cycle after the last of the declared N frame-data words is accepted, including N=1. A load that stops short or is aborted never pulses it.
- R6: inj_en is high from the cycle after a frame-data header is accepted through the cycle in which the last frame word is accepted. inj_region equals the latched region ID.
- R7: While inj_en is high, rr_out of the target region carries a nonzero 16-bit LFSR value that changes every cycle. Every other region passes rr_in through unchanged.
- R8: A read of register 12 with count N emits 0x0C1B2011 N times, one word per cycle with out_valid high. in_ready is 0 while words are emitted.
- R9: The command word 12 (capture) latches cap_state. A read of register 3 with count N returns the captured words from index 0 upward, wrapping after the last index.
- R10: The command word 13 (desync) and the abort input each return the block to the unsynchronised state. Abort also drops inj_en in the next cycle and suppresses the swap.
- R11: A header with opcode 00 or with a word count of 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Configuration word valid |
| in_data | input | 32 | Configuration word |
| in_ready | output | 1 | Decoder can accept a word |
| abort | input | 1 | Cancels any transfer and drops sync |
| out_valid | output | 1 | Readout word valid |
| out_data | output | 32 | Readout word (identification or captured state) |
| swap_strobe | output | 1 | One-cycle request to activate the new module |
| swap_region | output | 2 | Region ID for the swap |
| swap_module | output | 4 | Module ID for the swap |
| inj_en | output | 1 | Error injection active |
| inj_region | output | 2 | Region receiving injected errors |
| rr_in | input | 4x16 | Outputs of each reconfigurable region |
| rr_out | output | 4x16 | Region outputs as seen by the static logic |
| cap_state | input | 4x32 | State words of the current module |

## Verification
The load path is tried with four word patterns:
- a full three-word load;
- a one-word load;
- a load cut off by abort;
- frame headers sent before sync or with a wrong type field.

Together these separate "swap after the exact count" from "swap early", "swap on abort" and "no gate on sync". Garbage is sampled on consecutive cycles and against an idle neighbour region, which separates a moving LFSR from a stuck pattern or the wrong region. A readback longer than the capture buffer checks both word order and wrap-around. An identification read of two words checks repetition and input stalling.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

    localparam logic [31:0] SYNC_WORD = 32'hAA995566;
    localparam logic [31:0] ID_VALUE  = 32'h0C1B2011;

    localparam logic [2:0] PKT_TYPE1 = 3'b001;
    localparam logic [1:0] OP_READ   = 2'b01;
    localparam logic [1:0] OP_WRITE  = 2'b10;

    localparam logic [4:0] RA_FADDR = 5'd1;
    localparam logic [4:0] RA_FDATA = 5'd2;
    localparam logic [4:0] RA_FOUT  = 5'd3;
    localparam logic [4:0] RA_CMD   = 5'd4;
    localparam logic [4:0] RA_IDENT = 5'd12;

    localparam logic [31:0] CMD_CAPTURE = 32'd12;
    localparam logic [31:0] CMD_DESYNC  = 32'd13;

    localparam int CNT_W = 11;

    typedef enum logic [1:0] {
        ST_UNSYNC,
        ST_HEADER,
        ST_PAYLOAD,
        ST_READOUT
    } dec_state_e;

    typedef struct packed {
        logic [2:0]       ptype;
        logic [1:0]       op;
        logic [4:0]       addr;
        logic [CNT_W-1:0] cnt;
    } hdr_t;

    function automatic hdr_t split_hdr(input logic [31:0] w);
        hdr_t h;
        h.ptype = w[31:29];
        h.op    = w[28:27];
        h.addr  = w[17:13];
        h.cnt   = w[10:0];
        return h;
    endfunction

endpackage

// File: rtl/cfgd_lfsr.sv
module cfgd_lfsr #(
    parameter int         W    = 16,
    parameter logic [W-1:0] SEED = 'hACE1,
    parameter logic [W-1:0] TAPS = 'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (adv) begin
            q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
        end
    end

    p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);

    p_lfsr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> q != $past(q));

endmodule

// File: rtl/cfgd_capbuf.sv
module cfgd_capbuf #(
    parameter int N = 4,
    parameter int W = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grab,
    input  logic [N-1:0][W-1:0] state_in,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        word
);

    logic [N-1:0][W-1:0] store;

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store[g] <= '0;
            end else if (grab) begin
                store[g] <= state_in[g];
            end
        end
    end

    assign word = store[idx];

endmodule

// File: rtl/cfg_stream_decoder.sv
module cfg_stream_decoder
    import cfgd_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int RDW   = 16,
    parameter int MIDW  = 4,
    parameter int CAP_N = 4,
    parameter logic [RDW-1:0] LFSR_SEED = 'hACE1,
    parameter logic [RDW-1:0] LFSR_TAPS = 'hB400,
    localparam int RIDW = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CIW  = (CAP_N > 1) ? $clog2(CAP_N) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [31:0]                in_data,
    output logic                       in_ready,
    input  logic                       abort,
    output logic                       out_valid,
    output logic [31:0]                out_data,
    output logic                       swap_strobe,
    output logic [RIDW-1:0]            swap_region,
    output logic [MIDW-1:0]            swap_module,
    output logic                       inj_en,
    output logic [RIDW-1:0]            inj_region,
    input  logic [NREG-1:0][RDW-1:0]   rr_in,
    output logic [NREG-1:0][RDW-1:0]   rr_out,
    input  logic [CAP_N-1:0][31:0]     cap_state
);

    localparam int RID_LSB = 8;

    dec_state_e       state;
    logic [4:0]       pay_reg;
    logic [CNT_W-1:0] cnt;
    logic [RIDW-1:0]  far_rid;
    logic [MIDW-1:0]  far_mid;
    logic [CIW-1:0]   rd_idx;
    logic             rd_ident;
    logic             rd_fout;
    logic             swp_q;
    logic [RIDW-1:0]  swp_rid;
    logic [MIDW-1:0]  swp_mid;

    logic             acc;
    logic             cmd_grab;
    logic [RDW-1:0]   garbage;
    logic [31:0]      cap_word;
    hdr_t             hdr;

    assign acc = in_valid && in_ready;
    assign hdr = split_hdr(in_data);

    // State register and the registers it owns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_UNSYNC;
            pay_reg  <= '0;
            cnt      <= '0;
            far_rid  <= '0;
            far_mid  <= '0;
            rd_idx   <= '0;
            rd_ident <= 1'b0;
            rd_fout  <= 1'b0;
            swp_q    <= 1'b0;
            swp_rid  <= '0;
            swp_mid  <= '0;
        end else begin
            swp_q <= 1'b0;
            if (abort) begin
                state <= ST_UNSYNC;
            end else begin
                unique case (state)
                    ST_UNSYNC: begin
                        if (acc && in_data == SYNC_WORD) state <= ST_HEADER;
                    end
                    ST_HEADER: begin
                        if (acc && hdr.ptype == PKT_TYPE1 && hdr.cnt != '0) begin
                            if (hdr.op == OP_WRITE) begin
                                state   <= ST_PAYLOAD;
                                pay_reg <= hdr.addr;
                                cnt     <= hdr.cnt;
                            end else if (hdr.op == OP_READ) begin
                                state    <= ST_READOUT;
                                rd_ident <= (hdr.addr == RA_IDENT);
                                rd_fout  <= (hdr.addr == RA_FOUT);
                                rd_idx   <= '0;
                                cnt      <= hdr.cnt;
                            end
                        end
                    end
                    ST_PAYLOAD: begin
                        if (acc) begin
                            cnt <= cnt - 1'b1;
                            if (cnt == CNT_W'(1)) state <= ST_HEADER;
                            if (pay_reg == RA_FADDR) begin
                                far_rid <= in_data[RID_LSB +: RIDW];
                                far_mid <= in_data[0 +: MIDW];
                            end
                            if (pay_reg == RA_CMD && in_data == CMD_DESYNC) begin
                                state <= ST_UNSYNC;
                            end
                            if (pay_reg == RA_FDATA && cnt == CNT_W'(1)) begin
                                swp_q   <= 1'b1;
                                swp_rid <= far_rid;
                                swp_mid <= far_mid;
                            end
                        end
                    end
                    ST_READOUT: begin
                        cnt    <= cnt - 1'b1;
                        rd_idx <= (rd_idx == CIW'(CAP_N - 1)) ? '0 : rd_idx + 1'b1;
                        if (cnt == CNT_W'(1)) state <= ST_HEADER;
                    end
                    default: state <= ST_UNSYNC;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready    = (state != ST_READOUT);
        out_valid   = (state == ST_READOUT);
        out_data    = '0;
        if (out_valid) begin
            if (rd_ident)     out_data = ID_VALUE;
            else if (rd_fout) out_data = cap_word;
        end
        inj_en      = (state == ST_PAYLOAD) && (pay_reg == RA_FDATA);
        inj_region  = far_rid;
        swap_strobe = swp_q;
        swap_region = swp_rid;
        swap_module = swp_mid;
        cmd_grab    = acc && !abort && (state == ST_PAYLOAD)
                      && (pay_reg == RA_CMD) && (in_data == CMD_CAPTURE);
    end

    cfgd_lfsr #(
        .W    (RDW),
        .SEED (LFSR_SEED),
        .TAPS (LFSR_TAPS)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (inj_en),
        .q     (garbage)
    );

    cfgd_capbuf #(
        .N (CAP_N),
        .W (32)
    ) u_capbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .grab     (cmd_grab),
        .state_in (cap_state),
        .idx      (rd_idx),
        .word     (cap_word)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_iso
        assign rr_out[g] = (inj_en && inj_region == RIDW'(g)) ? garbage : rr_in[g];
    end

    p_swap_after_inject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_strobe |-> $past(inj_en));

    p_swap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_strobe |=> !swap_strobe);

    p_swap_ids_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swap_strobe |-> swap_region == $past(inj_region));

    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!inj_en && !swap_strobe && !out_valid));

    p_inject_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en |-> rr_out[inj_region] != '0);

endmodule

// File: tb/sim_cfg_stream_decoder.sv
`timescale 1ns/1ps
module sim_cfg_stream_decoder;

    localparam logic [31:0] SYNC = 32'hAA995566;
    localparam logic [31:0] IDV  = 32'h0C1B2011;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_data = '0;
    logic              in_ready;
    logic              abort = 1'b0;
    logic              out_valid;
    logic [31:0]       out_data;
    logic              swap_strobe;
    logic [1:0]        swap_region;
    logic [3:0]        swap_module;
    logic              inj_en;
    logic [1:0]        inj_region;
    logic [3:0][15:0]  rr_in;
    logic [3:0][15:0]  rr_out;
    logic [3:0][31:0]  cap_state;

    int nchk = 0;
    int nfail = 0;
    int swap_cnt = 0;
    logic [31:0] expq[$];

    always #2.5 clk = ~clk;

    cfg_stream_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .abort(abort), .out_valid(out_valid),
        .out_data(out_data), .swap_strobe(swap_strobe),
        .swap_region(swap_region), .swap_module(swap_module),
        .inj_en(inj_en), .inj_region(inj_region), .rr_in(rr_in),
        .rr_out(rr_out), .cap_state(cap_state)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input logic [1:0] op, input logic [4:0] ra, input logic [10:0] n);
        return {3'b001, op, 9'd0, ra, 2'd0, n};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Scoreboard monitor for the readout stream
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8/R9 unexpected readout word", out_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(out_data == e, "R8/R9 readout word", out_data, e);
            end
        end
        if (rst_n && swap_strobe) swap_cnt++;
    end

    initial begin : watchdog
        #(5.0 * 150000);
        nfail++;
        nchk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : stim
        logic [15:0] g0;
        rr_in = '{16'h4444, 16'h0000, 16'h2222, 16'h1111};
        cap_state = '{32'hD0D0_0003, 32'hC0C0_0002, 32'hB0B0_0001, 32'hA0A0_0000};
        idle(3);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", {31'd0, in_ready}, 32'd1);
        chk({out_valid, swap_strobe, inj_en} == 3'b000, "R1 outputs idle",
            {29'd0, out_valid, swap_strobe, inj_en}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R2 words before sync are dropped
        send(hdr(2'b10, 5'd2, 11'd2));
        chk(inj_en == 1'b0, "R2 no inject before sync", {31'd0, inj_en}, 32'd0);
        send(32'h1); send(32'h2);
        send(hdr(2'b01, 5'd12, 11'd1));
        idle(3);
        chk(swap_cnt == 0, "R2 no swap before sync", swap_cnt, 0);

        // R8 identification read, count 2
        send(SYNC);
        expq.push_back(IDV); expq.push_back(IDV);
        send(hdr(2'b01, 5'd12, 11'd2));
        chk(in_ready == 1'b0 && out_valid == 1'b1, "R8 stall during readout",
            {30'd0, in_ready, out_valid}, 32'd1);
        idle(3);
        chk(expq.size() == 0, "R8 both id words seen", expq.size(), 0);

        // R11 NOOP and zero count; R3 wrong type field
        send(32'h2000_0000);
        send(hdr(2'b10, 5'd2, 11'd0));
        chk(inj_en == 1'b0, "R11 zero count no load", {31'd0, inj_en}, 32'd0);
        send({3'b010, 2'b10, 9'd0, 5'd2, 2'd0, 11'd3});
        chk(inj_en == 1'b0, "R3 bad type ignored", {31'd0, inj_en}, 32'd0);

        // R4 R5 R6 R7 three-word load into region 2 module 9
        send(hdr(2'b10, 5'd1, 11'd1));
        send(32'h0000_0209);
        send(hdr(2'b10, 5'd2, 11'd3));
        chk(inj_en == 1'b1 && inj_region == 2'd2, "R6 inject on for region 2",
            {29'd0, inj_en, inj_region}, 32'h6);
        chk(rr_out[2] != 16'h0, "R7 target region garbled", {16'd0, rr_out[2]}, 32'h0);
        chk(rr_out[0] == 16'h1111 && rr_out[3] == 16'h4444, "R7 other regions pass",
            {rr_out[3], rr_out[0]}, 32'h4444_1111);
        g0 = rr_out[2];
        idle(1);
        chk(rr_out[2] != g0, "R7 garbage advances", {16'd0, rr_out[2]}, {16'd0, g0});
        send(32'hF00D_0001); send(32'hF00D_0002);
        chk(inj_en == 1'b1 && swap_strobe == 1'b0, "R5 no swap before last word",
            {30'd0, inj_en, swap_strobe}, 32'h2);
        send(32'hF00D_0003);
        chk(swap_strobe == 1'b1 && inj_en == 1'b0, "R5/R6 swap after last word",
            {30'd0, swap_strobe, inj_en}, 32'h2);
        chk(swap_region == 2'd2 && swap_module == 4'd9, "R4 identifiers",
            {26'd0, swap_region, swap_module}, 32'h29);
        chk(rr_out[2] == 16'h0000, "R7 region restored", {16'd0, rr_out[2]}, 32'h0);
        idle(1);
        chk(swap_strobe == 1'b0 && swap_cnt == 1, "R5 single pulse",
            swap_cnt, 1);

        // R10 abort mid-load
        send(hdr(2'b10, 5'd1, 11'd1));
        send(32'h0000_0105);
        send(hdr(2'b10, 5'd2, 11'd4));
        send(32'h1); send(32'h2);
        abort = 1'b1;
        idle(1);
        abort = 1'b0;
        chk(inj_en == 1'b0, "R10 abort drops inject", {31'd0, inj_en}, 32'd0);
        send(32'h3); send(32'h4);
        send(hdr(2'b01, 5'd12, 11'd1));
        idle(3);
        chk(swap_cnt == 1, "R10 aborted load never swaps", swap_cnt, 1);

        // R9 capture then readback of 5 words (wraps)
        send(SYNC);
        send(hdr(2'b10, 5'd4, 11'd1));
        send(32'd12);
        cap_state = '{32'h9, 32'h9, 32'h9, 32'h9};
        expq.push_back(32'hA0A0_0000); expq.push_back(32'hB0B0_0001);
        expq.push_back(32'hC0C0_0002); expq.push_back(32'hD0D0_0003);
        expq.push_back(32'hA0A0_0000);
        send(hdr(2'b01, 5'd3, 11'd5));
        idle(6);
        chk(expq.size() == 0, "R9 readback complete", expq.size(), 0);

        // R10 desync command
        send(hdr(2'b10, 5'd4, 11'd1));
        send(32'd13);
        send(hdr(2'b10, 5'd2, 11'd1));
        chk(inj_en == 1'b0, "R10 desync drops sync", {31'd0, inj_en}, 32'd0);

        // R5 boundary: one-word load into region 3 module 15
        send(SYNC);
        send(hdr(2'b10, 5'd1, 11'd1));
        send(32'h0000_030F);
        send(hdr(2'b10, 5'd2, 11'd1));
        chk(inj_en == 1'b1 && inj_region == 2'd3, "R6 inject region 3",
            {29'd0, inj_en, inj_region}, 32'h7);
        send(32'hBEEF);
        chk(swap_strobe == 1'b1 && swap_region == 2'd3 && swap_module == 4'hF,
            "R5/R4 one-word load swap", {25'd0, swap_strobe, swap_region, swap_module}, 32'h7F);
        idle(2);
        chk(swap_cnt == 2 && expq.size() == 0, "R5 total swaps", swap_cnt, 2);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule